// File: doc/BRIEF.md
# Protected Code Verify Read-Out

This block sits on the read path of an on-chip code memory while an external programmer verifies the stored image or reads the identification bytes. Each verify access combines the raw code byte with one byte of a 32-entry key table, chosen by the low five address bits: the result is the bitwise XNOR of the two bytes. A blank key table holds all ones, so an unkeyed part returns its code unchanged.

Two lock bits tighten protection step by step. Setting the first lock bit stops any further programming. It also raises two status lines for neighbouring logic: one blocks table reads from external code into internal memory, and one makes the external-access strap latch at reset. Setting both bits also suppresses verify data. A single erase strobe stands in for a full array erase: it refills the key table with ones and clears both lock bits. Identification reads return three fixed bytes and are neither keyed nor gated.

Top module: `vrf_readout`

## Requirements
- R1: With verify permitted, a cycle with `rd_en`=1 and `sig_mode`=0 yields `vdata` = ~(`code_byte` ^ key[`rd_addr`[4:0]]) and `vvalid`=1 on the following cycle.
- R2: After reset every key byte is FFh, so a verify read returns `code_byte` unchanged; `vvalid`, `prog_dis`, `movc_blk` and `ea_latch_en` are 0 and `vdata` is FFh.
- R3: `key_wr_en`=1 stores `key_wr_data` at entry `key_wr_idx`; reads in later cycles use the new value.
- R4: `lock_wr_en`=1 sets lock bit A when `lock_wr_sel`[0]=1 and lock bit B when `lock_wr_sel`[1]=1; a set lock bit is never cleared except by erase.
- R5: Once lock bit A is set, `prog_dis`, `movc_blk` and `ea_latch_en` are 1 from the next cycle on; with A set and B clear, verify reads still work as in R1.
- R6: While `prog_dis`=1, key writes and lock writes are ignored.
- R7: With both lock bits set, a verify read yields `vdata`=FFh and `vvalid`=0.
- R8: With only lock bit B set (reserved combination), all three status lines stay 0 and verify reads behave as in R1.
- R9: A read with `sig_mode`=1 yields, on the next cycle, 89h at address 0030h, 58h at 0031h, FBh at 0060h and FFh at any other address (all 16 bits compared), with `vvalid`=1, no keying, and no effect from the lock bits.
- R10: `erase`=1 sets every key byte to FFh and clears both lock bits from the next cycle; it takes priority over key or lock writes in the same cycle.
- R11: In a cycle with `rd_en`=0, `vvalid` is 0 on the next cycle and `vdata` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read request this cycle |
| sig_mode | input | 1 | 1 = identification read, 0 = verify read |
| rd_addr | input | 16 | Read address |
| code_byte | input | 8 | Raw byte from the code memory |
| key_wr_en | input | 1 | Key table write strobe |
| key_wr_idx | input | 5 | Key table entry to write |
| key_wr_data | input | 8 | Key byte to write |
| lock_wr_en | input | 1 | Lock programming strobe |
| lock_wr_sel | input | 2 | Bit 0 selects lock A, bit 1 selects lock B |
| erase | input | 1 | Erase strobe |
| vdata | output | 8 | Read-out byte |
| vvalid | output | 1 | Read-out byte is valid |
| prog_dis | output | 1 | Programming inhibited |
| movc_blk | output | 1 | Block external-code table reads of internal memory |
| ea_latch_en | output | 1 | Latch the external-access strap at reset |

## Verification
A corrupted key entry shows only at a verify read of an address whose low five bits select that entry, one cycle after the request, as a wrong `vdata` bit pattern. A lock bit in the wrong state shows at once on the three status lines when the bit is A. When the bit is B, it shows one cycle after the next verify read, as a dropped `vvalid` with forced FFh, or as data where none was expected. A write that slips through while locked shows only at a later read or status change, so the bench follows every blocked write with a read of the entry or lock it could have reached.

// File: rtl/vrf_pkg.sv
package vrf_pkg;

    // Lock state seen by the read path and status logic
    typedef enum logic [1:0] {
        LK_OPEN     = 2'b00,
        LK_NOPROG   = 2'b01,
        LK_RESERVED = 2'b10,
        LK_SEALED   = 2'b11
    } lock_lvl_t;

    // Identification table: three fixed address/byte pairs
    localparam logic [15:0] ID_ADDR0 = 16'h0030;
    localparam logic [15:0] ID_ADDR1 = 16'h0031;
    localparam logic [15:0] ID_ADDR2 = 16'h0060;
    localparam logic [7:0]  ID_BYTE0 = 8'h89;
    localparam logic [7:0]  ID_BYTE1 = 8'h58;
    localparam logic [7:0]  ID_BYTE2 = 8'hFB;

endpackage

// File: rtl/vrf_key_store.sv
module vrf_key_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          erase,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_key
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] key;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (erase) begin
                st_d.key[i] = '1;
            end else if (wr_en && (wr_idx == IW'(i))) begin
                st_d.key[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_key = st_q.key[rd_idx];

endmodule

// File: rtl/vrf_lock_ctrl.sv
module vrf_lock_ctrl
    import vrf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      erase,
    input  logic      wr_en,
    input  logic [1:0] wr_sel,
    output lock_lvl_t level,
    output logic      prog_dis,
    output logic      movc_blk,
    output logic      ea_latch_en,
    output logic      verify_dis
);

    typedef struct packed {
        logic lk_b;
        logic lk_a;
    } lock_t;

    lock_t lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (erase) begin
            lk_d = '0;
        end else if (wr_en && !lk_q.lk_a) begin
            lk_d.lk_a = lk_q.lk_a | wr_sel[0];
            lk_d.lk_b = lk_q.lk_b | wr_sel[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_q <= '0;
        end else begin
            lk_q <= lk_d;
        end
    end

    assign level       = lock_lvl_t'({lk_q.lk_b, lk_q.lk_a});
    assign prog_dis    = (level == LK_NOPROG) || (level == LK_SEALED);
    assign movc_blk    = prog_dis;
    assign ea_latch_en = prog_dis;
    assign verify_dis  = (level == LK_SEALED);

endmodule

// File: rtl/vrf_read_path.sv
module vrf_read_path
    import vrf_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          sig_mode,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] code,
    input  logic [DW-1:0] key,
    input  logic          verify_dis,
    output logic [DW-1:0] vdata,
    output logic          vvalid
);

    typedef struct packed {
        logic [DW-1:0] data;
        logic          valid;
    } out_t;

    out_t rp_d, rp_q;
    logic [DW-1:0] id_byte;

    always_comb begin
        id_byte = '1;
        if (addr == AW'(ID_ADDR0)) begin
            id_byte = DW'(ID_BYTE0);
        end else if (addr == AW'(ID_ADDR1)) begin
            id_byte = DW'(ID_BYTE1);
        end else if (addr == AW'(ID_ADDR2)) begin
            id_byte = DW'(ID_BYTE2);
        end
    end

    always_comb begin
        rp_d       = rp_q;
        rp_d.valid = 1'b0;
        if (rd_en) begin
            if (sig_mode) begin
                rp_d.data  = id_byte;
                rp_d.valid = 1'b1;
            end else if (verify_dis) begin
                rp_d.data  = '1;
            end else begin
                rp_d.data  = ~(code ^ key);
                rp_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp_q <= '{data: '1, valid: 1'b0};
        end else begin
            rp_q <= rp_d;
        end
    end

    assign vdata  = rp_q.data;
    assign vvalid = rp_q.valid;

endmodule

// File: rtl/vrf_readout.sv
module vrf_readout
    import vrf_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int KEY_DEPTH = 32,
    localparam int KIW      = $clog2(KEY_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              sig_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] code_byte,
    input  logic              key_wr_en,
    input  logic [KIW-1:0]    key_wr_idx,
    input  logic [DATA_W-1:0] key_wr_data,
    input  logic              lock_wr_en,
    input  logic [1:0]        lock_wr_sel,
    input  logic              erase,
    output logic [DATA_W-1:0] vdata,
    output logic              vvalid,
    output logic              prog_dis,
    output logic              movc_blk,
    output logic              ea_latch_en
);

    lock_lvl_t         lock_level;
    logic              verify_dis;
    logic              key_wr_ok;
    logic [DATA_W-1:0] sel_key;

    assign key_wr_ok = key_wr_en && !prog_dis;

    vrf_lock_ctrl u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .erase       (erase),
        .wr_en       (lock_wr_en),
        .wr_sel      (lock_wr_sel),
        .level       (lock_level),
        .prog_dis    (prog_dis),
        .movc_blk    (movc_blk),
        .ea_latch_en (ea_latch_en),
        .verify_dis  (verify_dis)
    );

    vrf_key_store #(
        .DEPTH (KEY_DEPTH),
        .DW    (DATA_W)
    ) u_keys (
        .clk     (clk),
        .rst_n   (rst_n),
        .erase   (erase),
        .wr_en   (key_wr_ok),
        .wr_idx  (key_wr_idx),
        .wr_data (key_wr_data),
        .rd_idx  (rd_addr[KIW-1:0]),
        .rd_key  (sel_key)
    );

    vrf_read_path #(
        .AW (ADDR_W),
        .DW (DATA_W)
    ) u_read (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .sig_mode   (sig_mode),
        .addr       (rd_addr),
        .code       (code_byte),
        .key        (sel_key),
        .verify_dis (verify_dis),
        .vdata      (vdata),
        .vvalid     (vvalid)
    );

endmodule

// File: rtl/vrf_readout_chk.sv
module vrf_readout_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              sig_mode,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              erase,
    input logic [DATA_W-1:0] vdata,
    input logic              vvalid,
    input logic              prog_dis,
    input logic              movc_blk,
    input logic              ea_latch_en
);

    assert_open_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !sig_mode && !prog_dis) |=> vvalid);

    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_dis && !erase) |=> prog_dis);

    assert_sealed_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (vvalid || (vdata == '1)));

    assert_id_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sig_mode && (rd_addr == ADDR_W'(16'h0030)))
        |=> (vvalid && (vdata == DATA_W'(8'h89))));

    assert_erase_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (!prog_dis && !movc_blk && !ea_latch_en));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!vvalid && $stable(vdata)));

endmodule

bind vrf_readout vrf_readout_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (.*);

// File: tb/vrf_readout_test.sv
module vrf_readout_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rd_en, sig_mode;
    logic [15:0] rd_addr;
    logic [7:0]  code_byte;
    logic        key_wr_en;
    logic [4:0]  key_wr_idx;
    logic [7:0]  key_wr_data;
    logic        lock_wr_en;
    logic [1:0]  lock_wr_sel;
    logic        erase;
    logic [7:0]  vdata;
    logic        vvalid, prog_dis, movc_blk, ea_latch_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    vrf_readout uut (.*);

    // {sig_mode, addr, code, expected}; key[i] is loaded as ~i so verify = code ^ i
    localparam logic [32:0] TBL [10] = '{
        {1'b0, 16'h1234, 8'hA5, 8'hB1},
        {1'b0, 16'h0000, 8'h3C, 8'h3C},
        {1'b0, 16'h001F, 8'h00, 8'h1F},
        {1'b0, 16'hFFE7, 8'hFF, 8'hF8},
        {1'b0, 16'h0021, 8'h80, 8'h81},
        {1'b1, 16'h0030, 8'h12, 8'h89},
        {1'b1, 16'h0031, 8'h12, 8'h58},
        {1'b1, 16'h0060, 8'h12, 8'hFB},
        {1'b1, 16'h0061, 8'h12, 8'hFF},
        {1'b1, 16'h1030, 8'h12, 8'hFF}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        rd_en = 0; sig_mode = 0; rd_addr = '0; code_byte = '0;
        key_wr_en = 0; key_wr_idx = '0; key_wr_data = '0;
        lock_wr_en = 0; lock_wr_sel = '0; erase = 0;
    endtask

    task automatic rd(input logic sm, input logic [15:0] a, input logic [7:0] c);
        quiet();
        rd_en = 1; sig_mode = sm; rd_addr = a; code_byte = c;
        step();
        quiet();
    endtask

    task automatic lock(input logic [1:0] sel);
        quiet();
        lock_wr_en = 1; lock_wr_sel = sel;
        step();
        quiet();
    endtask

    task automatic status(input string req, input logic e);
        chk(req, {5'b0, prog_dis, movc_blk, ea_latch_en}, {5'b0, e, e, e});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        quiet();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R2: reset state
        chk("R2 vvalid", {7'b0, vvalid}, 8'h00);
        chk("R2 vdata", vdata, 8'hFF);
        status("R2 status", 1'b0);
        rd(1'b0, 16'h0005, 8'h6B);
        chk("R2 blank keys", vdata, 8'h6B);
        chk("R2 valid", {7'b0, vvalid}, 8'h01);

        // R3: load key[i] = ~i
        for (int i = 0; i < 32; i++) begin
            quiet();
            key_wr_en = 1; key_wr_idx = 5'(i); key_wr_data = ~8'(i);
            step();
        end
        quiet();

        // R1 / R3 / R9 table walk
        for (int i = 0; i < 10; i++) begin
            rd(TBL[i][32], TBL[i][31:16], TBL[i][15:8]);
            chk(TBL[i][32] ? "R9 id data" : "R1 R3 verify data", vdata, TBL[i][7:0]);
            chk(TBL[i][32] ? "R9 id valid" : "R1 verify valid", {7'b0, vvalid}, 8'h01);
        end

        // R11: idle keeps data, drops valid
        rd(1'b0, 16'h0014, 8'hA5);
        quiet();
        step();
        chk("R11 vvalid", {7'b0, vvalid}, 8'h00);
        chk("R11 vdata hold", vdata, 8'hB1);

        // R8: only lock B
        lock(2'b10);
        status("R8 status", 1'b0);
        rd(1'b0, 16'h0014, 8'hA5);
        chk("R8 verify", vdata, 8'hB1);
        chk("R8 valid", {7'b0, vvalid}, 8'h01);

        // R4 / R5 / R7: add lock A, B kept
        lock(2'b01);
        status("R5 status", 1'b1);
        rd(1'b0, 16'h0014, 8'hA5);
        chk("R7 R4 sealed data", vdata, 8'hFF);
        chk("R7 R4 sealed valid", {7'b0, vvalid}, 8'h00);
        rd(1'b1, 16'h0031, 8'h00);
        chk("R9 id under seal", vdata, 8'h58);
        chk("R9 id valid under seal", {7'b0, vvalid}, 8'h01);

        // R10: erase clears locks and keys
        quiet();
        erase = 1;
        step();
        quiet();
        status("R10 status", 1'b0);
        rd(1'b0, 16'h0014, 8'hA5);
        chk("R10 keys blank", vdata, 8'hA5);

        // R5: lock A alone keeps verify
        lock(2'b01);
        status("R5 A only", 1'b1);
        rd(1'b0, 16'h0003, 8'h4D);
        chk("R5 verify open", vdata, 8'h4D);
        chk("R5 verify valid", {7'b0, vvalid}, 8'h01);

        // R6: writes ignored while programming is inhibited
        quiet();
        key_wr_en = 1; key_wr_idx = 5'd3; key_wr_data = 8'h00;
        lock_wr_en = 1; lock_wr_sel = 2'b10;
        step();
        quiet();
        rd(1'b0, 16'h0003, 8'h4D);
        chk("R6 key write ignored", vdata, 8'h4D);
        chk("R6 lock write ignored", {7'b0, vvalid}, 8'h01);

        // R10: erase beats simultaneous writes
        quiet();
        erase = 1;
        key_wr_en = 1; key_wr_idx = 5'd2; key_wr_data = 8'h00;
        lock_wr_en = 1; lock_wr_sel = 2'b11;
        step();
        quiet();
        status("R10 priority status", 1'b0);
        rd(1'b0, 16'h0002, 8'h55);
        chk("R10 priority key", vdata, 8'h55);
        chk("R10 priority valid", {7'b0, vvalid}, 8'h01);

        finish_run();
    end

endmodule